// File: doc/BRIEF.md
# Skew Alignment Delay Code Calculator

This block turns three measured arrival times, one each for the red, green and blue video channels, into three delay codes. A programmable delay line uses these codes to bring the channels back into time alignment. The channel that arrives last is left without added delay. Every earlier channel is padded by its lag behind that channel, expressed in whole delay steps.

Arrival times are unsigned numbers in units of 0.1 ns. The block captures all three on a one-cycle start pulse and then works for a fixed number of cycles.

- In the scan phase it walks the captured times one channel per cycle to find the latest arrival.
- In the calculate phase it walks the channels again. For each one it forms the lag, divides by the step of 8 units (0.8 ns) rounding to the nearest code, and writes the code register.
- A lag that needs more than the top code 63 (about 50 ns) is clamped to 63, and that channel's saturation flag is raised.

A common propagation delay shared by all channels plays no part, because only differences between the channels are used.

The controller has four states:

- IDLE waits for start.
- SCAN compares one channel per cycle against the running maximum.
- CALC writes one channel's code per cycle.
- FINISH raises done for one cycle.

The transitions are:

- IDLE goes to SCAN on start ("accept").
- SCAN goes to CALC after the last channel ("scan_end").
- CALC goes to FINISH after the last channel ("calc_end").
- FINISH always returns to IDLE ("retire").

A start pulse in any state other than IDLE is ignored.

Top module: `skew_align_top`

## Requirements
- R1: While rst is high at a clock edge (synchronous, active high), the block is cleared. In the cycle after, all three codes are 0, all sat bits are 0 and done is 0.
- R2: When done is high, the channel with the largest captured arrival time has code 0.
- R3: Every other channel's code is round((tmax - t) / 8), with times in 0.1 ns units and a remainder of 4 or more rounding up. A lag of 4 gives 1, a lag of 3 gives 0 and a lag of 12 gives 2.
- R4: When the rounded value exceeds 63, the code is 63 and that channel's sat bit is 1; otherwise the sat bit is 0. The sat bits are: bit 0 red, bit 1 green, bit 2 blue. A lag of 507 gives 63 with sat 0, and a lag of 508 gives 63 with sat 1.
- R5: When two or three channels tie for the latest arrival, every tied channel gets code 0.
- R6: done is high for exactly one cycle. It is first seen 7 clock edges after the edge that accepted start, counting that edge as the first.
- R7: Arrival times are captured only at the accepted start. A start pulse while a calculation is in progress produces no extra done and no change of result, and neither does any later change of the time inputs.
- R8: Codes and sat bits hold their values between calculations.
- R9: If green is latest, red lags by 40 ns and blue lags by 28 ns, the codes are red 50, green 0 and blue 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; times are captured when accepted in IDLE |
| t_red | input | TIME_W (10) | Red arrival time, 0.1 ns units |
| t_grn | input | TIME_W (10) | Green arrival time, 0.1 ns units |
| t_blu | input | TIME_W (10) | Blue arrival time, 0.1 ns units |
| code_red | output | CODE_W (6) | Red delay code |
| code_grn | output | CODE_W (6) | Green delay code |
| code_blu | output | CODE_W (6) | Blue delay code |
| sat | output | 3 | Per-channel clamp flag (bit 0 red, 1 green, 2 blue) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:

- the clearing after reset;
- that done lasts a single cycle and follows a code write;
- that a sat bit never appears without the top code;
- that at least one code is zero whenever done is high;
- that codes and flags stay frozen outside the calculate phase.

The exact numeric codes, the round-half-up boundaries, the 507/508 clamp edge, ties and the seven-edge latency can only be shown by the bench's scenarios. The same is true of ignoring a start pulse or input change during a calculation. For these the bench compares against an independently computed expectation.

// File: rtl/skew_pkg.sv
package skew_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_CALC,
        S_FINISH
    } skew_state_e;
endpackage

// File: rtl/skew_ctrl_fsm.sv
module skew_ctrl_fsm
    import skew_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             accept,
    output logic             scan_en,
    output logic             calc_en,
    output logic             done,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    skew_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // transitions: accept, scan_end, calc_end, retire
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start)       nxt = S_SCAN;
            S_SCAN:   if (idx == LAST) nxt = S_CALC;
            S_CALC:   if (idx == LAST) nxt = S_FINISH;
            S_FINISH:                  nxt = S_IDLE;
            default:                   nxt = S_IDLE;
        endcase
    end

    // channel walker shared by both phases
    always_ff @(posedge clk) begin
        if (rst || state == S_IDLE || state == S_FINISH) idx <= '0;
        else if (idx == LAST)                          idx <= '0;
        else                                           idx <= idx + 1'b1;
    end

    // outputs from state
    always_comb begin
        accept  = 1'b0;
        scan_en = 1'b0;
        calc_en = 1'b0;
        done    = 1'b0;
        unique case (state)
            S_IDLE:   accept  = start;
            S_SCAN:   scan_en = 1'b1;
            S_CALC:   calc_en = 1'b1;
            S_FINISH: done    = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/skew_max_scan.sv
module skew_max_scan #(
    parameter int TIME_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [TIME_W-1:0] sample,
    output logic [TIME_W-1:0] max_q
);
    always_ff @(posedge clk) begin
        if (rst || clear)             max_q <= '0;
        else if (en && sample > max_q) max_q <= sample;
    end
endmodule

// File: rtl/skew_quant.sv
module skew_quant #(
    parameter int TIME_W = 10,
    parameter int CODE_W = 6,
    parameter int STEP   = 8
) (
    input  logic [TIME_W-1:0] lag,
    output logic [CODE_W-1:0] code,
    output logic              sat
);
    localparam int SUM_W = TIME_W + 1;
    localparam logic [SUM_W-1:0] HALF_V   = SUM_W'(STEP / 2);
    localparam logic [SUM_W-1:0] STEP_V   = SUM_W'(STEP);
    localparam logic [SUM_W-1:0] CODE_TOP = SUM_W'((1 << CODE_W) - 1);

    logic [SUM_W-1:0] biased;
    logic [SUM_W-1:0] steps;

    always_comb begin
        biased = {1'b0, lag} + HALF_V;
        steps  = biased / STEP_V;
        sat    = steps > CODE_TOP;
        code   = sat ? {CODE_W{1'b1}} : steps[CODE_W-1:0];
    end
endmodule

// File: rtl/skew_align_top.sv
module skew_align_top
    import skew_pkg::*;
#(
    parameter int TIME_W = 10,
    parameter int CODE_W = 6,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] t_red,
    input  logic [TIME_W-1:0] t_grn,
    input  logic [TIME_W-1:0] t_blu,
    output logic [CODE_W-1:0] code_red,
    output logic [CODE_W-1:0] code_grn,
    output logic [CODE_W-1:0] code_blu,
    output logic [NCH-1:0]    sat,
    output logic              done
);
    localparam int IDX_W = $clog2(NCH);

    logic             accept, scan_en, calc_en;
    logic [IDX_W-1:0] idx;
    logic [TIME_W-1:0] t_in  [NCH];
    logic [TIME_W-1:0] t_lat [NCH];
    logic [CODE_W-1:0] code_q [NCH];
    logic [NCH-1:0]    sat_q;
    logic [TIME_W-1:0] sel_t, max_t, lag;
    logic [CODE_W-1:0] q_code;
    logic              q_sat;

    assign t_in[0] = t_red;
    assign t_in[1] = t_grn;
    assign t_in[2] = t_blu;

    skew_ctrl_fsm #(.NUM_CH(NCH), .IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .accept  (accept),
        .scan_en (scan_en),
        .calc_en (calc_en),
        .done    (done),
        .idx     (idx)
    );

    // pick the channel under the walker
    always_comb begin
        sel_t = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (idx == IDX_W'(ch)) sel_t = t_lat[ch];
        end
    end

    skew_max_scan #(.TIME_W(TIME_W)) u_max (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .en     (scan_en),
        .sample (sel_t),
        .max_q  (max_t)
    );

    assign lag = max_t - sel_t;

    skew_quant #(.TIME_W(TIME_W), .CODE_W(CODE_W), .STEP(STEP)) u_quant (
        .lag  (lag),
        .code (q_code),
        .sat  (q_sat)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)         t_lat[ch] <= '0;
            else if (accept) t_lat[ch] <= t_in[ch];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[ch] <= '0;
                sat_q[ch]  <= 1'b0;
            end else if (calc_en && idx == IDX_W'(ch)) begin
                code_q[ch] <= q_code;
                sat_q[ch]  <= q_sat;
            end
        end
    end

    assign code_red = code_q[0];
    assign code_grn = code_q[1];
    assign code_blu = code_q[2];
    assign sat      = sat_q;
endmodule

// File: rtl/skew_align_chk.sv
module skew_align_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              calc_en,
    input logic [CODE_W-1:0] code_red,
    input logic [CODE_W-1:0] code_grn,
    input logic [CODE_W-1:0] code_blu,
    input logic [2:0]        sat
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && code_red == '0 && code_grn == '0 && code_blu == '0 && sat == 3'b000));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(calc_en));

    // R2
    latest_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (code_red == '0 || code_grn == '0 || code_blu == '0));

    // R4
    sat_red_chk: assert property (@(posedge clk) disable iff (rst)
        sat[0] |-> code_red == TOP);

    // R4
    sat_grn_chk: assert property (@(posedge clk) disable iff (rst)
        sat[1] |-> code_grn == TOP);

    // R4
    sat_blu_chk: assert property (@(posedge clk) disable iff (rst)
        sat[2] |-> code_blu == TOP);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !calc_en |=> $stable({code_red, code_grn, code_blu, sat}));
endmodule

bind skew_align_top skew_align_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .calc_en  (calc_en),
    .code_red (code_red),
    .code_grn (code_grn),
    .code_blu (code_blu),
    .sat      (sat)
);

// File: tb/skew_align_top_test.sv
module skew_align_top_test;
    typedef struct packed {
        logic [5:0] cr;
        logic [5:0] cg;
        logic [5:0] cb;
        logic [2:0] s;
        int         at;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [9:0] t_red = '0, t_grn = '0, t_blu = '0;
    logic [5:0] code_red, code_grn, code_blu;
    logic [2:0] sat;
    logic       done;

    int   total = 0;
    int   bad   = 0;
    int   cyc   = 0;
    logic prev_done = 1'b0;
    exp_t sb[$];
    exp_t last;

    skew_align_top uut (
        .clk(clk), .rst(rst), .start(start),
        .t_red(t_red), .t_grn(t_grn), .t_blu(t_blu),
        .code_red(code_red), .code_grn(code_grn), .code_blu(code_blu),
        .sat(sat), .done(done)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model(input int tr, input int tg, input int tb,
                                  output logic [5:0] c [3], output logic [2:0] s);
        int t [3];
        int mx;
        int q;
        t[0] = tr; t[1] = tg; t[2] = tb;
        mx = tr;
        if (tg > mx) mx = tg;
        if (tb > mx) mx = tb;
        for (int i = 0; i < 3; i++) begin
            q = (mx - t[i] + 4) / 8;
            s[i] = (q > 63);
            c[i] = (q > 63) ? 6'd63 : q[5:0];
        end
    endfunction

    task automatic run_case(int tr, int tg, int tb);
        exp_t e;
        logic [5:0] c [3];
        logic [2:0] s;
        model(tr, tg, tb, c, s);
        @(negedge clk);
        e.cr = c[0]; e.cg = c[1]; e.cb = c[2]; e.s = s; e.at = cyc + 7;
        sb.push_back(e);
        last = e;
        t_red = 10'(tr); t_grn = 10'(tg); t_blu = 10'(tb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // monitor: pop and compare on each done
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) check("R6 done width", int'(done), 0);
            if (done) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R2/R3/R9 code_red", int'(code_red), int'(e.cr));
                    check("R2/R3/R9 code_grn", int'(code_grn), int'(e.cg));
                    check("R2/R3/R9 code_blu", int'(code_blu), int'(e.cb));
                    check("R4 sat", int'(sat), int'(e.s));
                    check("R6 latency", cyc, e.at);
                end
            end
        end
        prev_done = done;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 code_red", int'(code_red), 0);
        check("R1 code_grn", int'(code_grn), 0);
        check("R1 code_blu", int'(code_blu), 0);
        check("R1 sat", int'(sat), 0);
        check("R1 done", int'(done), 0);

        // R9 green latest, red 40 ns behind, blue 28 ns behind
        run_case(200, 600, 320);
        // R3 rounding: lag 4 -> 1, lag 3 -> 0
        run_case(500, 496, 497);
        // R3 lag 12 -> 2, lag 11 -> 1
        run_case(489, 488, 500);
        // R5 tie red/blue, R4 green saturates
        run_case(700, 100, 700);
        // R4 boundary: lag 507 -> 63 no sat, lag 508 -> 63 sat
        run_case(493, 492, 1000);
        // R5 three-way tie
        run_case(333, 333, 333);

        // R7 start while busy and input change are ignored
        begin
            exp_t e;
            logic [5:0] c [3];
            logic [2:0] s;
            model(100, 260, 180, c, s);
            @(negedge clk);
            e.cr = c[0]; e.cg = c[1]; e.cb = c[2]; e.s = s; e.at = cyc + 7;
            sb.push_back(e);
            last = e;
            t_red = 10'd100; t_grn = 10'd260; t_blu = 10'd180;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            t_red = 10'd900; t_grn = 10'd5; t_blu = 10'd44;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (14) @(negedge clk);
            check("R7 queue drained", sb.size(), 0);
        end

        // R8 outputs hold between calculations
        repeat (20) @(negedge clk);
        check("R8 code_red hold", int'(code_red), int'(last.cr));
        check("R8 code_grn hold", int'(code_grn), int'(last.cg));
        check("R8 code_blu hold", int'(code_blu), int'(last.cb));
        check("R8 sat hold", int'(sat), int'(last.s));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule